// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This block is the purely combinational datapath slice that an 8-bit processor core uses for its byte-oriented shift, rotate and single-bit operations. A decoder upstream hands it a 4-bit operation code, a bit index, the operand byte (taken from a register or from a byte already fetched from memory) and the current carry flag. In the same cycle the unit returns the new byte, the four condition flags (zero, subtract, half-carry, carry), a mask that says which flags the core should commit, and a write-enable for the result.

Two families of rotate share one datapath. The long, prefixed forms take the zero flag from the result. The short accumulator forms always clear it. Bit test only reads the operand: it writes no result and leaves carry untouched. Bit set and bit clear change exactly one bit and touch no flags. Operand fetch, write-back sequencing and cycle counting belong to the surrounding core.

Top module: `srb_unit`

## Requirements
- R1: Code 2 rotates left through carry: carry_in enters bit 0 and the old bit 7 becomes flag_c. Code 3 is the mirror: carry_in enters bit 7 and the old bit 0 becomes flag_c.
- R2: Code 0 rotates left circularly and code 1 rotates right circularly. The carry is not part of the loop. The bit that wraps around is also copied to flag_c.
- R3: Code 4 shifts left, fills bit 0 with 0 and moves the old bit 7 into flag_c.
- R4: Code 5 shifts right, keeps bit 7 at its old value and moves the old bit 0 into flag_c.
- R5: Code 7 shifts right, fills bit 7 with 0 and moves the old bit 0 into flag_c.
- R6: Code 6 swaps the upper and lower nibbles, sets flag_z when the result is zero, and clears flag_n, flag_h and flag_c.
- R7: For codes 0 to 7, flag_z is 1 exactly when the result is zero, and flag_n and flag_h are 0. flag_mask is 4'b1111 and result_we is 1. The flag_mask bit order is {Z,N,H,C} from bit 3 down to bit 0.
- R8: Codes 8, 9, 10 and 11 are the accumulator forms. They give the same result and flag_c as codes 0, 1, 2 and 3, but force flag_z, flag_n and flag_h to 0, with flag_mask 4'b1111 and result_we 1.
- R9: Code 12 tests bit bit_idx: flag_z is 1 when that bit is 0, flag_n is 0, flag_h is 1 and flag_c equals carry_in. flag_mask is 4'b1110, result_we is 0 and result equals operand.
- R10: Code 13 clears and code 14 sets bit bit_idx, where index 0 is the least significant bit. All other bits pass through, result_we is 1 and flag_mask is 0. flag_z, flag_n and flag_h are 0 and flag_c equals carry_in.
- R11: Code 15 performs no operation: result equals operand, result_we is 0, flag_mask is 0, flag_z, flag_n and flag_h are 0 and flag_c equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select, codes 0 to 15 |
| bit_idx | input | 3 | Bit position for test, set and clear |
| operand | input | 8 | Source byte |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Produced byte |
| flag_z | output | 1 | New zero flag |
| flag_n | output | 1 | New subtract flag |
| flag_h | output | 1 | New half-carry flag |
| flag_c | output | 1 | New carry flag |
| flag_mask | output | 4 | Flags to commit, {Z,N,H,C} |
| result_we | output | 1 | Result should be written back |

## Verification
The bound checker evaluates, at every settled input change, the properties that do not depend on the exact bit pattern. These are the flag rules of each operation class, the write-enable and mask per code, and the fact that set and clear change at most the indexed bit. It also checks that circular rotates and the nibble swap conserve the number of ones, and that bit test and code 15 return the operand unchanged. The direction of each shift, the value shifted in, which bit falls into carry and where bit index 0 lies can only be seen in the bench's directed edge bytes and its random vectors, which it compares against its own reference model.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SWAP = 4'd6,
        OP_SRL  = 4'd7,
        OP_RLCA = 4'd8,
        OP_RRCA = 4'd9,
        OP_RLA  = 4'd10,
        OP_RRA  = 4'd11,
        OP_BIT  = 4'd12,
        OP_RES  = 4'd13,
        OP_SET  = 4'd14,
        OP_NONE = 4'd15
    } srb_op_e;

    typedef enum logic [2:0] {
        CL_PREF,
        CL_ACC,
        CL_TEST,
        CL_MODIFY,
        CL_IDLE
    } srb_class_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } srb_flags_t;

endpackage

// File: rtl/srb_shifter.sv
module srb_shifter #(
    parameter int WIDTH = 8
) (
    input  logic [2:0]       kind,
    input  logic [WIDTH-1:0] din,
    input  logic             cin,
    output logic [WIDTH-1:0] dout,
    output logic             cout
);
    localparam int HALF = WIDTH / 2;

    always_comb begin
        unique case (kind)
            3'd0: begin dout = {din[WIDTH-2:0], din[WIDTH-1]}; cout = din[WIDTH-1]; end
            3'd1: begin dout = {din[0], din[WIDTH-1:1]};       cout = din[0];       end
            3'd2: begin dout = {din[WIDTH-2:0], cin};          cout = din[WIDTH-1]; end
            3'd3: begin dout = {cin, din[WIDTH-1:1]};          cout = din[0];       end
            3'd4: begin dout = {din[WIDTH-2:0], 1'b0};         cout = din[WIDTH-1]; end
            3'd5: begin dout = {din[WIDTH-1], din[WIDTH-1:1]}; cout = din[0];       end
            3'd6: begin dout = {din[HALF-1:0], din[WIDTH-1:HALF]}; cout = 1'b0;     end
            default: begin dout = {1'b0, din[WIDTH-1:1]};      cout = din[0];       end
        endcase
    end
endmodule

// File: rtl/srb_bitops.sv
module srb_bitops #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [1:0]       mode,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             picked
);
    logic [WIDTH-1:0] sel;

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign sel[i] = (idx == IDX_W'(i));
    end

    assign picked = |(din & sel);

    always_comb begin
        unique case (mode)
            2'd1:    dout = din & ~sel;
            2'd2:    dout = din | sel;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/srb_flag_gen.sv
module srb_flag_gen
    import srb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  srb_class_e       cls,
    input  logic [WIDTH-1:0] res,
    input  logic             sh_cout,
    input  logic             cin,
    input  logic             picked,
    output srb_flags_t       flags,
    output logic [3:0]       mask,
    output logic             we
);
    logic res_zero;
    assign res_zero = (res == '0);

    always_comb begin
        flags = '{z: 1'b0, n: 1'b0, h: 1'b0, c: cin};
        mask  = 4'b0000;
        we    = 1'b0;
        unique case (cls)
            CL_PREF: begin
                flags.z = res_zero;
                flags.c = sh_cout;
                mask    = 4'b1111;
                we      = 1'b1;
            end
            CL_ACC: begin
                flags.c = sh_cout;
                mask    = 4'b1111;
                we      = 1'b1;
            end
            CL_TEST: begin
                flags.z = ~picked;
                flags.h = 1'b1;
                mask    = 4'b1110;
            end
            CL_MODIFY: begin
                we      = 1'b1;
            end
            default: begin
                we      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
    import srb_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [3:0]       op_code,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [WIDTH-1:0] operand,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_h,
    output logic             flag_c,
    output logic [3:0]       flag_mask,
    output logic             result_we
);
    srb_op_e          op;
    srb_class_e       cls;
    logic [WIDTH-1:0] sh_res;
    logic             sh_cout;
    logic [WIDTH-1:0] bo_res;
    logic             picked;
    srb_flags_t       flags;

    assign op = srb_op_e'(op_code);

    always_comb begin
        unique case (op)
            OP_RLC, OP_RRC, OP_RL, OP_RR,
            OP_SLA, OP_SRA, OP_SWAP, OP_SRL: cls = CL_PREF;
            OP_RLCA, OP_RRCA, OP_RLA, OP_RRA: cls = CL_ACC;
            OP_BIT:                           cls = CL_TEST;
            OP_RES, OP_SET:                   cls = CL_MODIFY;
            default:                          cls = CL_IDLE;
        endcase
    end

    srb_shifter #(.WIDTH(WIDTH)) i_shifter (
        .kind (op_code[2:0]),
        .din  (operand),
        .cin  (carry_in),
        .dout (sh_res),
        .cout (sh_cout)
    );

    srb_bitops #(.WIDTH(WIDTH)) i_bitops (
        .mode   (op_code[1:0]),
        .idx    (bit_idx),
        .din    (operand),
        .dout   (bo_res),
        .picked (picked)
    );

    always_comb begin
        unique case (cls)
            CL_PREF, CL_ACC: result = sh_res;
            CL_MODIFY:       result = bo_res;
            default:         result = operand;
        endcase
    end

    srb_flag_gen #(.WIDTH(WIDTH)) i_flag_gen (
        .cls     (cls),
        .res     (result),
        .sh_cout (sh_cout),
        .cin     (carry_in),
        .picked  (picked),
        .flags   (flags),
        .mask    (flag_mask),
        .we      (result_we)
    );

    assign flag_z = flags.z;
    assign flag_n = flags.n;
    assign flag_h = flags.h;
    assign flag_c = flags.c;
endmodule

// File: rtl/srb_unit_chk.sv
module srb_unit_chk #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input logic [3:0]       op_code,
    input logic [IDX_W-1:0] bit_idx,
    input logic [WIDTH-1:0] operand,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_h,
    input logic             flag_c,
    input logic [3:0]       flag_mask,
    input logic             result_we
);
    logic [WIDTH-1:0] keep;
    assign keep = ~(WIDTH'(1) << bit_idx);

    always_comb begin
        if (op_code < 4'd8) begin
            p_pref_flags_r7: assert (flag_z == (result == '0) && !flag_n && !flag_h
                                     && flag_mask == 4'b1111 && result_we)
                else $error("prefixed flag rule broken");
        end
        if (op_code >= 4'd8 && op_code <= 4'd11) begin
            p_acc_flags_r8: assert (!flag_z && !flag_n && !flag_h
                                    && flag_mask == 4'b1111 && result_we)
                else $error("accumulator flag rule broken");
        end
        if (op_code == 4'd0 || op_code == 4'd8) begin
            p_circ_left_r2: assert ($countones(result) == $countones(operand) && flag_c == result[0])
                else $error("circular left rule broken");
        end
        if (op_code == 4'd1 || op_code == 4'd9) begin
            p_circ_right_r2: assert ($countones(result) == $countones(operand) && flag_c == result[WIDTH-1])
                else $error("circular right rule broken");
        end
        if (op_code == 4'd6) begin
            p_swap_r6: assert (!flag_c && $countones(result) == $countones(operand))
                else $error("swap rule broken");
        end
        if (op_code == 4'd12) begin
            p_test_r9: assert (!result_we && result == operand && flag_h && !flag_n
                               && flag_c == carry_in && flag_mask == 4'b1110)
                else $error("bit test rule broken");
        end
        if (op_code == 4'd13 || op_code == 4'd14) begin
            p_modify_r10: assert (result_we && flag_mask == 4'b0000
                                  && ((result ^ operand) & keep) == '0)
                else $error("bit modify rule broken");
        end
        if (op_code == 4'd15) begin
            p_idle_r11: assert (!result_we && flag_mask == 4'b0000 && result == operand)
                else $error("idle code rule broken");
        end
    end
endmodule

bind srb_unit srb_unit_chk #(.WIDTH(WIDTH)) i_srb_unit_chk (.*);

// File: tb/test_srb_unit.sv
module test_srb_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = 4'd15;
    logic [2:0] bit_idx = 3'd0;
    logic [7:0] operand = 8'd0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       flag_z, flag_n, flag_h, flag_c;
    logic [3:0] flag_mask;
    logic       result_we;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    srb_unit i_srb_unit (
        .op_code   (op_code),
        .bit_idx   (bit_idx),
        .operand   (operand),
        .carry_in  (carry_in),
        .result    (result),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_h    (flag_h),
        .flag_c    (flag_c),
        .flag_mask (flag_mask),
        .result_we (result_we)
    );

    // expected {result[7:0], z, n, h, c, mask[3:0], we}
    function automatic logic [16:0] model(input logic [3:0] op, input logic [2:0] ix,
                                          input logic [7:0] a, input logic ci);
        logic [7:0] r;
        logic z, n, h, c, we;
        logic [3:0] m;
        r = a; z = 1'b0; n = 1'b0; h = 1'b0; c = ci; m = 4'b0000; we = 1'b0;
        case (op)
            4'd0, 4'd8:  begin r = (a << 1) | (a >> 7);       c = a[7]; end
            4'd1, 4'd9:  begin r = (a >> 1) | (a << 7);       c = a[0]; end
            4'd2, 4'd10: begin r = (a << 1) | {7'd0, ci};     c = a[7]; end
            4'd3, 4'd11: begin r = (a >> 1) | {ci, 7'd0};     c = a[0]; end
            4'd4:        begin r = a << 1;                    c = a[7]; end
            4'd5:        begin r = (a >> 1) | (a & 8'h80);    c = a[0]; end
            4'd6:        begin r = (a << 4) | (a >> 4);       c = 1'b0; end
            4'd7:        begin r = a >> 1;                    c = a[0]; end
            4'd12:       begin z = ((a >> ix) & 8'd1) == 8'd0; h = 1'b1; m = 4'b1110; end
            4'd13:       begin r = a & ~(8'd1 << ix); we = 1'b1; end
            4'd14:       begin r = a | (8'd1 << ix);  we = 1'b1; end
            default: ;
        endcase
        if (op < 4'd8) begin z = (r == 8'd0); m = 4'b1111; we = 1'b1; end
        else if (op < 4'd12) begin m = 4'b1111; we = 1'b1; end
        return {r, z, n, h, c, m, we};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd2, 4'd3:   return "R1";
            4'd0, 4'd1:   return "R2";
            4'd4:         return "R3";
            4'd5:         return "R4";
            4'd7:         return "R5";
            4'd6:         return "R6";
            4'd12:        return "R9";
            4'd13, 4'd14: return "R10";
            4'd15:        return "R11";
            default:      return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [2:0] ix,
                         input logic [7:0] a, input logic ci);
        logic [16:0] e;
        string ftag;
        @(negedge clk);
        op_code = op; bit_idx = ix; operand = a; carry_in = ci;
        #2;
        e = model(op, ix, a, ci);
        ftag = (op < 4'd8 && op != 4'd6) ? "R7" : tag_of(op);
        check(tag_of(op), {8'd0, result}, {8'd0, e[16:9]});
        check(ftag, {7'd0, flag_z, flag_n, flag_h, flag_c, flag_mask, result_we},
              {7'd0, e[8:0]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R11: idle code after start
        apply(4'd15, 3'd0, 8'h5A, 1'b1);
        // R1: carry through rotates
        apply(4'd2, 3'd0, 8'h80, 1'b0);
        apply(4'd3, 3'd0, 8'h01, 1'b1);
        // R2: circular rotates
        apply(4'd0, 3'd0, 8'h81, 1'b0);
        apply(4'd1, 3'd0, 8'h01, 1'b0);
        // R3, R4, R5: shifts at edges
        apply(4'd4, 3'd0, 8'h80, 1'b1);
        apply(4'd5, 3'd0, 8'h81, 1'b0);
        apply(4'd7, 3'd0, 8'h01, 1'b1);
        // R6: swap, zero and non-zero
        apply(4'd6, 3'd0, 8'hF0, 1'b1);
        apply(4'd6, 3'd0, 8'h00, 1'b1);
        // R8: accumulator rotate giving zero byte still clears Z
        apply(4'd10, 3'd0, 8'h80, 1'b0);
        apply(4'd8, 3'd0, 8'h80, 1'b0);
        // R9: bit test at both ends
        apply(4'd12, 3'd7, 8'h7F, 1'b1);
        apply(4'd12, 3'd0, 8'h01, 1'b0);
        // R10: index 0 is the least significant bit
        apply(4'd14, 3'd0, 8'h00, 1'b0);
        apply(4'd13, 3'd7, 8'hFF, 1'b1);
        for (int k = 0; k < 1500; k++) begin
            apply(4'($urandom_range(15, 0)), 3'($urandom_range(7, 0)),
                  8'($urandom_range(255, 0)), 1'($urandom_range(1, 0)));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule